// File: doc/BRIEF.md
# Control-Flow Step Classifier

This block looks at the opcode bytes at the current program counter before the processor runs them. It tells a debugger's step-over and step-out logic whether that instruction is a subroutine call, a restart, or a return. For conditional forms it also reports whether the branch will be taken under the present flags. It also gives the address at which execution resumes after a call, which is the address of the next instruction in memory.

The caller presents the first opcode byte, the byte after it, the 16-bit program counter and the packed flags byte, then pulses a valid strobe. On the next clock edge the block registers a kind code, a taken bit and a 16-bit return address, and raises a one-cycle done pulse. Strobes may arrive on back-to-back cycles. Each one produces its own result one cycle later.

Top module: `flow_classifier`

## Requirements
- R1: While reset is asserted and after it is released, `res_done`, `res_kind`, `res_taken` and `res_ret_addr` are all zero until the first strobe is accepted.
- R2: `res_done` is high in exactly the cycle after a cycle with `in_valid` high. The result outputs change only on that edge and otherwise hold their values.
- R3: Opcode 0xCD (unconditional call) gives kind 1 (call), taken 1, and return address PC+3.
- R4: Opcodes of the form 0b11ccc100 (conditional call) give kind 1 and return address PC+3. Taken equals the condition selected by ccc.
- R5: Opcodes of the form 0b11ttt111 (restart, all eight targets) give kind 2 (restart), taken 1, and return address PC+1.
- R6: Opcode 0xC9 (unconditional return) gives kind 3 (return), taken 1, and return address PC+1.
- R7: Opcodes of the form 0b11ccc000 (conditional return) give kind 3 and return address PC+1. Taken equals the condition selected by ccc.
- R8: First byte 0xED followed by 0x45, 0x4D, 0x55, 0x5D, 0x65, 0x6D, 0x75 or 0x7D gives kind 3, taken 1, and return address PC+2.
- R9: The condition field ccc selects, for values 0 to 7: Z clear, Z set, C clear, C set, P/V clear, P/V set, S clear, S set. Within the flags byte, S is bit 7, Z is bit 6, P/V is bit 2 and C is bit 0.
- R10: Any other opcode, including 0xED followed by a byte not listed in R8, gives kind 0 (none), taken 0 and return address 0.
- R11: The return address is computed modulo 2^16. For example, a call at 0xFFFF returns to 0x0002.
- R12: Flag bits 5, 4, 3 and 1 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: classify the presented bytes this cycle |
| in_op0 | input | 8 | Opcode byte at PC |
| in_op1 | input | 8 | Byte at PC+1 (used after a 0xED prefix) |
| in_pc | input | 16 | Program counter of the instruction |
| in_flags | input | 8 | Packed flags byte (S=7, Z=6, P/V=2, C=0) |
| res_done | output | 1 | One-cycle pulse marking a fresh result |
| res_kind | output | 2 | 0 none, 1 call, 2 restart, 3 return |
| res_taken | output | 1 | The transfer will happen |
| res_ret_addr | output | 16 | PC plus instruction length, or 0 for kind none |

## Verification
Two situations can fall in the same clock edge. The first is a result being presented while the next strobe is captured. The second is a conditional evaluation combined with a return address that wraps past 0xFFFF. The bench drives strobes on consecutive cycles, mixing conditional forms with PCs near the top of the address space. A scoreboard queue pairs each done pulse with the entry pushed when that strobe was driven, so any lost, merged or shifted result shows up as a mismatch or as a done pulse with nothing queued.

// File: rtl/flowcls_pkg.sv
package flowcls_pkg;

   typedef enum logic [1:0] {
      FK_NONE = 2'd0,
      FK_CALL = 2'd1,
      FK_RST  = 2'd2,
      FK_RET  = 2'd3
   } flow_kind_e;

   // Decoder output bundle
   typedef struct packed {
      flow_kind_e kind;
      logic       is_cond;
      logic [2:0] ccc;
      logic [1:0] len;
   } decode_t;

   localparam logic [7:0] OP_CALL   = 8'hCD;
   localparam logic [7:0] OP_RET    = 8'hC9;
   localparam logic [7:0] OP_PREFIX = 8'hED;
   localparam logic [7:0] OP_RETN   = 8'h45;
   localparam logic [7:0] OP_RETI   = 8'h4D;

endpackage

// File: rtl/flowcls_decode.sv
module flowcls_decode
   import flowcls_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter bit ALIAS_EN = 1'b1
) (
   input  logic [DATA_W-1:0] op0,
   input  logic [DATA_W-1:0] op1,
   output decode_t           dec
);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("flowcls_decode: DATA_W must be 8");
      end
   endgenerate

   logic top_two;
   logic ed_ret;

   assign top_two = (op0[7:6] == 2'b11);

   // Prefixed return recognition: either the two primary codes only,
   // or the whole 01xxx101 alias family.
   generate
      if (ALIAS_EN) begin : g_alias
         assign ed_ret = (op0[7:0] == OP_PREFIX) &&
                         (op1[7:6] == 2'b01) && (op1[2:0] == 3'b101);
      end else begin : g_strict
         assign ed_ret = (op0[7:0] == OP_PREFIX) &&
                         ((op1[7:0] == OP_RETN) || (op1[7:0] == OP_RETI));
      end
   endgenerate

   always_comb begin
      dec         = '0;
      dec.kind    = FK_NONE;
      dec.ccc     = op0[5:3];
      if (op0[7:0] == OP_CALL) begin
         dec.kind = FK_CALL;
         dec.len  = 2'd3;
      end else if (top_two && op0[2:0] == 3'b100) begin
         dec.kind    = FK_CALL;
         dec.is_cond = 1'b1;
         dec.len     = 2'd3;
      end else if (top_two && op0[2:0] == 3'b111) begin
         dec.kind = FK_RST;
         dec.len  = 2'd1;
      end else if (op0[7:0] == OP_RET) begin
         dec.kind = FK_RET;
         dec.len  = 2'd1;
      end else if (top_two && op0[2:0] == 3'b000) begin
         dec.kind    = FK_RET;
         dec.is_cond = 1'b1;
         dec.len     = 2'd1;
      end else if (ed_ret) begin
         dec.kind = FK_RET;
         dec.len  = 2'd2;
      end
   end

endmodule

// File: rtl/flowcls_cond.sv
module flowcls_cond #(
   parameter int FLAG_W = 8,
   parameter int S_BIT  = 7,
   parameter int Z_BIT  = 6,
   parameter int P_BIT  = 2,
   parameter int C_BIT  = 0
) (
   input  logic [FLAG_W-1:0] flags,
   input  logic [2:0]        ccc,
   output logic              holds
);

   generate
      if (S_BIT >= FLAG_W || Z_BIT >= FLAG_W || P_BIT >= FLAG_W || C_BIT >= FLAG_W)
      begin : g_bad_bits
         $error("flowcls_cond: flag bit position outside flags width");
      end
   endgenerate

   logic [3:0] tested;
   logic       picked;

   // ccc[2:1] picks the flag, ccc[0] picks the polarity
   assign tested = {flags[S_BIT], flags[P_BIT], flags[C_BIT], flags[Z_BIT]};
   assign picked = tested[ccc[2:1]];
   assign holds  = ccc[0] ? picked : ~picked;

endmodule

// File: rtl/flowcls_addr.sv
module flowcls_addr #(
   parameter int ADDR_W = 16,
   parameter int LEN_W  = 2
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [LEN_W-1:0]  len,
   input  logic              zero_out,
   output logic [ADDR_W-1:0] next
);

   generate
      if (ADDR_W <= LEN_W) begin : g_bad_addr
         $error("flowcls_addr: ADDR_W too small");
      end
   endgenerate

   logic [ADDR_W-1:0] sum;

   assign sum  = pc + ADDR_W'(len);
   assign next = zero_out ? '0 : sum;

endmodule

// File: rtl/flow_classifier.sv
module flow_classifier
   import flowcls_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int FLAG_W   = 8,
   parameter bit ALIAS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_op0,
   input  logic [DATA_W-1:0] in_op1,
   input  logic [ADDR_W-1:0] in_pc,
   input  logic [FLAG_W-1:0] in_flags,
   output logic              res_done,
   output logic [1:0]        res_kind,
   output logic              res_taken,
   output logic [ADDR_W-1:0] res_ret_addr
);

   localparam int LEN_W = 2;

   decode_t           dec;
   logic              cond_ok;
   logic              taken_c;
   logic [ADDR_W-1:0] addr_c;

   flowcls_decode #(.DATA_W(DATA_W), .ALIAS_EN(ALIAS_EN)) u_dec (
      .op0 (in_op0),
      .op1 (in_op1),
      .dec (dec)
   );

   flowcls_cond #(.FLAG_W(FLAG_W)) u_cond (
      .flags (in_flags),
      .ccc   (dec.ccc),
      .holds (cond_ok)
   );

   flowcls_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
      .pc       (in_pc),
      .len      (dec.len),
      .zero_out (dec.kind == FK_NONE),
      .next     (addr_c)
   );

   assign taken_c = (dec.kind != FK_NONE) && (!dec.is_cond || cond_ok);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_done     <= 1'b0;
         res_kind     <= 2'd0;
         res_taken    <= 1'b0;
         res_ret_addr <= '0;
      end else begin
         res_done <= in_valid;
         if (in_valid) begin
            res_kind     <= dec.kind;
            res_taken    <= taken_c;
            res_ret_addr <= addr_c;
         end
      end
   end

endmodule

// File: rtl/flowcls_chk.sv
module flowcls_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_op0,
   input logic [ADDR_W-1:0] in_pc,
   input logic              res_done,
   input logic [1:0]        res_kind,
   input logic              res_taken,
   input logic [ADDR_W-1:0] res_ret_addr
);

   // R2
   done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_done);

   // R2
   done_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !res_done);

   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(res_kind) && $stable(res_taken) && $stable(res_ret_addr)));

   // R10
   none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_done && res_kind == 2'd0) |-> (!res_taken && res_ret_addr == '0));

   // R5
   rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_done && res_kind == 2'd2) |-> (res_taken && res_ret_addr == $past(in_pc) + ADDR_W'(1)));

   // R3
   call_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_done && res_kind == 2'd1) |-> (res_ret_addr == $past(in_pc) + ADDR_W'(3)));

   // R8
   ret_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_done && res_kind == 2'd3) |->
      (res_ret_addr == $past(in_pc) + (($past(in_op0) == 8'hED) ? ADDR_W'(2) : ADDR_W'(1))));

endmodule

bind flow_classifier flowcls_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_op0       (in_op0),
   .in_pc        (in_pc),
   .res_done     (res_done),
   .res_kind     (res_kind),
   .res_taken    (res_taken),
   .res_ret_addr (res_ret_addr)
);

// File: tb/flow_classifier_test.sv
`timescale 1ns/1ps
module flow_classifier_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_op0 = '0;
   logic [7:0]  in_op1 = '0;
   logic [15:0] in_pc = '0;
   logic [7:0]  in_flags = '0;
   logic        res_done;
   logic [1:0]  res_kind;
   logic        res_taken;
   logic [15:0] res_ret_addr;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [1:0]  kind;
      logic        taken;
      logic [15:0] addr;
      string       req;
   } exp_t;

   exp_t sb[$];

   always #2.5 clk = ~clk;

   flow_classifier uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_op0(in_op0), .in_op1(in_op1), .in_pc(in_pc), .in_flags(in_flags),
      .res_done(res_done), .res_kind(res_kind), .res_taken(res_taken),
      .res_ret_addr(res_ret_addr)
   );

   // Condition truth from R9
   function automatic logic cond_true(input logic [2:0] cc, input logic [7:0] f);
      case (cc)
         3'd0: return !f[6];
         3'd1: return  f[6];
         3'd2: return !f[0];
         3'd3: return  f[0];
         3'd4: return !f[2];
         3'd5: return  f[2];
         3'd6: return !f[7];
         default: return f[7];
      endcase
   endfunction

   function automatic exp_t predict(input logic [7:0] a, input logic [7:0] b,
                                    input logic [15:0] pc, input logic [7:0] f,
                                    input string req);
      exp_t e;
      e.req = req; e.kind = 2'd0; e.taken = 1'b0; e.addr = 16'h0000;
      if (a == 8'hCD) begin
         e.kind = 2'd1; e.taken = 1'b1; e.addr = pc + 16'd3;
      end else if (a[7:6] == 2'b11 && a[2:0] == 3'b100) begin
         e.kind = 2'd1; e.taken = cond_true(a[5:3], f); e.addr = pc + 16'd3;
      end else if (a[7:6] == 2'b11 && a[2:0] == 3'b111) begin
         e.kind = 2'd2; e.taken = 1'b1; e.addr = pc + 16'd1;
      end else if (a == 8'hC9) begin
         e.kind = 2'd3; e.taken = 1'b1; e.addr = pc + 16'd1;
      end else if (a[7:6] == 2'b11 && a[2:0] == 3'b000) begin
         e.kind = 2'd3; e.taken = cond_true(a[5:3], f); e.addr = pc + 16'd1;
      end else if (a == 8'hED && (b == 8'h45 || b == 8'h4D || b == 8'h55 || b == 8'h5D ||
                                  b == 8'h65 || b == 8'h6D || b == 8'h75 || b == 8'h7D)) begin
         e.kind = 2'd3; e.taken = 1'b1; e.addr = pc + 16'd2;
      end
      return e;
   endfunction

   // Driver: one strobe per call, back-to-back when called repeatedly
   task automatic drive(input logic [7:0] a, input logic [7:0] b,
                        input logic [15:0] pc, input logic [7:0] f, input string req);
      sb.push_back(predict(a, b, pc, f, req));
      in_op0 = a; in_op1 = b; in_pc = pc; in_flags = f; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Monitor: compares at the falling edge
   always @(negedge clk) begin
      if (rst_n && !finished && res_done) begin
         if (sb.size() == 0) begin
            check(1'b0, "R2", "done with nothing queued", 32'(res_done), 32'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(res_kind == e.kind, e.req, "kind", 32'(res_kind), 32'(e.kind));
            check(res_taken == e.taken, e.req, "taken", 32'(res_taken), 32'(e.taken));
            check(res_ret_addr == e.addr, e.req, "ret_addr", 32'(res_ret_addr), 32'(e.addr));
         end
      end
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [1:0]  k0;
      logic [15:0] a0;
      logic        t0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(res_done == 0 && res_kind == 0 && res_taken == 0 && res_ret_addr == 0,
            "R1", "reset outputs", {13'd0, res_done, res_kind, res_taken, res_ret_addr}, 32'd0);
      rst_n = 1'b1;
      idle(2);
      check(res_done == 0 && res_kind == 0 && res_ret_addr == 0, "R1", "after release",
            32'(res_ret_addr), 32'd0);

      drive(8'hCD, 8'h00, 16'h1234, 8'h00, "R3");
      idle(1);
      for (int cc = 0; cc < 8; cc++) begin
         drive({2'b11, 3'(cc), 3'b100}, 8'h00, 16'h2000, 8'h00, "R4 R9");
         drive({2'b11, 3'(cc), 3'b100}, 8'h00, 16'h2000, 8'hC5, "R4 R9");
      end
      for (int t = 0; t < 8; t++) drive({2'b11, 3'(t), 3'b111}, 8'h00, 16'h0400 + 16'(t), 8'h00, "R5");
      drive(8'hC9, 8'h00, 16'h3000, 8'hFF, "R6");
      for (int cc = 0; cc < 8; cc++) begin
         drive({2'b11, 3'(cc), 3'b000}, 8'h00, 16'h4000, 8'h00, "R7 R9");
         drive({2'b11, 3'(cc), 3'b000}, 8'h00, 16'h4000, 8'hC5, "R7 R9");
      end
      // single-flag patterns for R9
      drive(8'hC4, 8'h00, 16'h5000, 8'h40, "R9");
      drive(8'hD4, 8'h00, 16'h5000, 8'h01, "R9");
      drive(8'hE4, 8'h00, 16'h5000, 8'h04, "R9");
      drive(8'hF4, 8'h00, 16'h5000, 8'h80, "R9");
      for (int j = 0; j < 8; j++) drive(8'hED, {2'b01, 3'(j), 3'b101}, 16'h6000, 8'h00, "R8");
      drive(8'hED, 8'h44, 16'h6100, 8'h00, "R10");
      drive(8'hED, 8'h4E, 16'h6100, 8'h00, "R10");
      drive(8'h00, 8'h45, 16'h6100, 8'h00, "R10");
      drive(8'hC3, 8'h00, 16'h6100, 8'hFF, "R10");
      drive(8'h3E, 8'hC9, 16'h6100, 8'hFF, "R10");
      // wrap
      drive(8'hCD, 8'h00, 16'hFFFF, 8'h00, "R11");
      drive(8'hDC, 8'h00, 16'hFFFE, 8'h00, "R11");
      drive(8'hED, 8'h4D, 16'hFFFE, 8'h00, "R11");
      drive(8'hFF, 8'h00, 16'hFFFF, 8'h00, "R11");
      // ignored flag bits: toggling bits 5,4,3,1
      drive(8'hC8, 8'h00, 16'h7000, 8'h3A, "R12");
      drive(8'hC8, 8'h00, 16'h7000, 8'h00, "R12");
      drive(8'hF0, 8'h00, 16'h7000, 8'h3A, "R12");
      idle(2);
      // R2 hold after idle, strobe inputs changed but not valid
      k0 = res_kind; a0 = res_ret_addr; t0 = res_taken;
      in_op0 = 8'hCD; in_pc = 16'h9999; in_flags = 8'hFF;
      idle(3);
      check(res_done == 0, "R2", "done idle", 32'(res_done), 32'd0);
      check(res_kind == k0 && res_ret_addr == a0 && res_taken == t0, "R2", "hold",
            32'(res_ret_addr), 32'(a0));
      idle(2);
      check(sb.size() == 0, "R2", "results outstanding", 32'(sb.size()), 32'd0);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule